// File: doc/BRIEF.md
# Flash Protected-Range Access Checker

This block guards a serial flash device against unwanted reads and writes. It holds five 32-bit range registers. Each register marks a window of the flash address space, with 4 KiB granularity, and carries its own read-protect and write-protect enables. Every access request, made up of a 25-bit flash address and a read/write flag, is compared against all five windows at once. One clock later the block returns a grant, or a deny with a flag that says whether a read or a write was refused.

Early in boot, firmware programs the windows through a simple register port. It then raises the lockdown input, and from that point the windows cannot be changed. Only a reset clears the lockdown bit, and the same reset also clears every window.

Top module: `flash_guard`

## Requirements
- R1: Range register layout: bits 12:0 hold the start page, bit 15 the read-protect enable, bits 28:16 the end page and bit 31 the write-protect enable. A page is address bits 24:12. Bits 13, 14, 29 and 30 are not stored and read back as 0. Writes to an index of 5 or higher are dropped, and reading such an index returns 0.
- R2: A write is denied when some range with write-protect set covers its address. A range covers every address from start page × 4096 up to and including end page × 4096 + 0xFFF.
- R3: A read is denied when some range with read-protect set covers its address. The same inclusive bounds apply as in R2.
- R4: A range whose end page is below its start page covers no address, whatever its enables are.
- R5: A range blocks only the access types whose enable is set. With both enables clear, the range has no effect.
- R6: When lockdown is set, range register writes are ignored. A write made in the same cycle in which the lock request is first sampled still takes effect.
- R7: Software cannot clear the lockdown bit once it is set. Reset returns the lockdown bit and all range registers to 0, and after reset every access is granted.
- R8: The response is registered. rsp_valid is high exactly in the cycle after req_valid was high. In that cycle exactly one of rsp_grant, rsp_deny_wr and rsp_deny_rd is high: rsp_deny_wr for a denied write, rsp_deny_rd for a denied read. When rsp_valid is low, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears ranges and lockdown |
| cfg_we | input | 1 | Range register write strobe |
| cfg_idx | input | 3 | Range register index for write and read |
| cfg_wdata | input | 32 | Range register write data |
| cfg_rdata | output | 32 | Contents of the selected range register (combinational) |
| lock_req | input | 1 | Sets the lockdown bit |
| lock_q | output | 1 | Current lockdown state |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 25 | Flash byte address |
| rsp_valid | output | 1 | Verdict present (one cycle after request) |
| rsp_grant | output | 1 | Access allowed |
| rsp_deny_wr | output | 1 | Write refused |
| rsp_deny_rd | output | 1 | Read refused |

## Verification
A bit stored in the wrong place in a range register shows up straight away on cfg_rdata. It also shows up in the next cycle as a verdict that flips on a page at a window edge. For that reason, the vectors probe the first and last byte of each window and the pages just outside it. A lockdown that leaks, or one that releases, only shows up after a later write attempt. So the bench tries to rewrite a locked window and then checks both the readback and a request in the next cycle. An off-by-one in the inclusive end page, or a missing empty-range rule, changes the grant for exactly one boundary page.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  localparam int ADDR_W   = 25;
  localparam int PAGE_LSB = 12;
  localparam int PAGE_W   = ADDR_W - PAGE_LSB;

  typedef struct packed {
    logic              wp;
    logic [PAGE_W-1:0] last_pg;
    logic              rp;
    logic [PAGE_W-1:0] first_pg;
  } range_t;

  // Unpack the 32-bit register image into the stored fields.
  function automatic range_t decode_range(input logic [31:0] w);
    range_t r;
    r.first_pg = w[PAGE_W-1:0];
    r.rp       = w[15];
    r.last_pg  = w[16 +: PAGE_W];
    r.wp       = w[31];
    return r;
  endfunction

  // Rebuild the register image; bits that are not stored read as zero.
  function automatic logic [31:0] encode_range(input range_t r);
    logic [31:0] w;
    w = '0;
    w[PAGE_W-1:0]   = r.first_pg;
    w[15]           = r.rp;
    w[16 +: PAGE_W] = r.last_pg;
    w[31]           = r.wp;
    return w;
  endfunction

  // Inclusive page-window test; an inverted window covers nothing.
  function automatic logic page_in_window(input logic [PAGE_W-1:0] pg,
                                          input range_t r);
    return (r.last_pg >= r.first_pg) && (pg >= r.first_pg) && (pg <= r.last_pg);
  endfunction

endpackage

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
  import flash_guard_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [IDX_W-1:0]          cfg_idx,
  input  logic [31:0]               cfg_wdata,
  output logic [31:0]               cfg_rdata,
  input  logic                      lock_req,
  output logic                      lock_q,
  output range_t [NUM_RANGES-1:0]   ranges
);

  range_t [NUM_RANGES-1:0] ranges_q;
  logic                    wr_accept;
  logic                    idx_valid;
  logic                    unused_wbits;

  assign idx_valid    = (32'(cfg_idx) < NUM_RANGES);
  assign wr_accept    = cfg_we && idx_valid && !lock_q;
  assign unused_wbits = ^{cfg_wdata[30:29], cfg_wdata[14:13]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_req) begin
      lock_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ranges_q[i] <= '0;
      end else if (wr_accept && (32'(cfg_idx) == i)) begin
        ranges_q[i] <= decode_range(cfg_wdata);
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (32'(cfg_idx) == i) cfg_rdata = encode_range(ranges_q[i]);
    end
  end

  assign ranges = ranges_q;

  // R6: once locked, the stored windows never move
  assert_locked_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(ranges_q));

  // R7: lockdown is sticky until reset
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R1: an out-of-range index reads zero
  assert_bad_idx_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_valid |-> (cfg_rdata == 32'd0));

endmodule

// File: rtl/flash_guard_match.sv
module flash_guard_match
  import flash_guard_pkg::*;
#(
  parameter int NUM_RANGES = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  range_t [NUM_RANGES-1:0] ranges,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    wr_block,
  output logic                    rd_block
);

  logic [PAGE_W-1:0]     req_page;
  logic [NUM_RANGES-1:0] covers;
  logic [NUM_RANGES-1:0] wr_hit;
  logic [NUM_RANGES-1:0] rd_hit;
  logic                  unused_offset;

  assign req_page      = req_addr[ADDR_W-1:PAGE_LSB];
  assign unused_offset = ^req_addr[PAGE_LSB-1:0];

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_win
    assign covers[i] = page_in_window(req_page, ranges[i]);
    assign wr_hit[i] = covers[i] && ranges[i].wp;
    assign rd_hit[i] = covers[i] && ranges[i].rp;

    // R4: inverted window never produces a hit
    assert_empty_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ranges[i].last_pg < ranges[i].first_pg) |-> !(wr_hit[i] || rd_hit[i]));

    // R5: a hit of a type needs that type's enable
    assert_hit_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[i] |-> ranges[i].wp) and (rd_hit[i] |-> ranges[i].rp));
  end

  assign wr_block = |wr_hit;
  assign rd_block = |rd_hit;

endmodule

// File: rtl/flash_guard_verdict.sv
module flash_guard_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic wr_block,
  input  logic rd_block,
  output logic rsp_valid,
  output logic rsp_grant,
  output logic rsp_deny_wr,
  output logic rsp_deny_rd
);

  logic deny_now;

  assign deny_now = req_write ? wr_block : rd_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_grant   <= 1'b0;
      rsp_deny_wr <= 1'b0;
      rsp_deny_rd <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_grant   <= req_valid && !deny_now;
      rsp_deny_wr <= req_valid && deny_now && req_write;
      rsp_deny_rd <= req_valid && deny_now && !req_write;
    end
  end

  // R8: verdict follows the request by one cycle
  assert_rsp_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_grant || rsp_deny_wr || rsp_deny_rd));

  assert_rsp_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_grant, rsp_deny_wr, rsp_deny_rd}) == 1));

  // R2 / R3: deny reason matches the access type of the request
  assert_reason_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> !rsp_deny_rd);

  assert_reason_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> !rsp_deny_wr);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = $clog2(NUM_RANGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              lock_req,
  output logic              lock_q,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_deny_wr,
  output logic              rsp_deny_rd
);

  range_t [NUM_RANGES-1:0] ranges;
  logic                    wr_block;
  logic                    rd_block;

  flash_guard_regs #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .lock_req  (lock_req),
    .lock_q    (lock_q),
    .ranges    (ranges)
  );

  flash_guard_match #(.NUM_RANGES(NUM_RANGES)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .ranges   (ranges),
    .req_addr (req_addr),
    .wr_block (wr_block),
    .rd_block (rd_block)
  );

  flash_guard_verdict u_verdict (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .wr_block    (wr_block),
    .rd_block    (rd_block),
    .rsp_valid   (rsp_valid),
    .rsp_grant   (rsp_grant),
    .rsp_deny_wr (rsp_deny_wr),
    .rsp_deny_rd (rsp_deny_rd)
  );

endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lock_req = 1'b0;
  logic        lock_q;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [24:0] req_addr = '0;
  logic        rsp_valid, rsp_grant, rsp_deny_wr, rsp_deny_rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  flash_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lock_req(lock_req),
    .lock_q(lock_q), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
    .rsp_deny_wr(rsp_deny_wr), .rsp_deny_rd(rsp_deny_rd)
  );

  // {write, address, expect write-deny, expect read-deny}
  localparam int NV = 14;
  localparam logic [27:0] VECS [NV] = '{
    {1'b1, 25'h000FFFF, 1'b0, 1'b0},  // R2 page below window 0
    {1'b1, 25'h0010000, 1'b1, 1'b0},  // R2 first byte of window 0
    {1'b1, 25'h001FFFF, 1'b1, 1'b0},  // R2 last byte, inclusive end
    {1'b1, 25'h0020000, 1'b0, 1'b0},  // R2 page above window 0
    {1'b0, 25'h0015000, 1'b0, 1'b0},  // R5 read in write-only window
    {1'b0, 25'h0100ABC, 1'b0, 1'b1},  // R3 read in window 1
    {1'b1, 25'h0100ABC, 1'b0, 1'b0},  // R5 write in read-only window
    {1'b0, 25'h00FFFFF, 1'b0, 1'b0},  // R3 just below window 1
    {1'b0, 25'h0101000, 1'b0, 1'b0},  // R3 just above window 1
    {1'b1, 25'h0045000, 1'b0, 1'b0},  // R4 inverted window 2
    {1'b0, 25'h0050000, 1'b0, 1'b0},  // R4 start page of inverted window
    {1'b1, 25'h0305000, 1'b0, 1'b0},  // R5 window 3 with no enables
    {1'b0, 25'h1FFFFFF, 1'b0, 1'b1},  // R3 top of flash, window 4
    {1'b1, 25'h1FF0000, 1'b1, 1'b0}   // R2 window 4 start
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_read(input string tag, input logic [2:0] idx, input logic [31:0] exp);
    @(negedge clk);
    cfg_idx = idx;
    #1 check(tag, cfg_rdata, exp);
  endtask

  // drive one request at a falling edge, sample the verdict one edge later
  task automatic access(input string tag, input logic wr, input logic [24:0] a,
                        input logic exp_dw, input logic exp_dr);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {28'd0, rsp_valid, rsp_grant, rsp_deny_wr, rsp_deny_rd},
          {28'd0, 1'b1, !(exp_dw || exp_dr), exp_dw, exp_dr});
  endtask

  task automatic program_windows();
    reg_write(3'd0, 32'h801F0010);  // wp, pages 0x010..0x01F
    reg_write(3'd1, 32'h01008100);  // rp, page 0x100 only
    reg_write(3'd2, 32'h80408050);  // both enables, inverted
    reg_write(3'd3, 32'h030F0300);  // no enables
    reg_write(3'd4, 32'h9FFF9FF0);  // both, pages 0x1FF0..0x1FFF
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 reset lock", {31'd0, lock_q}, 32'd0);
    check("R8 reset rsp", {28'd0, rsp_valid, rsp_grant, rsp_deny_wr, rsp_deny_rd}, 32'd0);
    rst_n = 1'b1;
    reg_read("R7 reset range0", 3'd0, 32'd0);

    // R1: layout and readback of unstored bits / bad index
    reg_write(3'd3, 32'hFFFFFFFF);
    reg_read("R1 unstored bits", 3'd3, 32'h9FFF9FFF);
    reg_write(3'd6, 32'h12345678);
    reg_read("R1 bad index", 3'd6, 32'd0);

    program_windows();
    reg_read("R1 readback w0", 3'd0, 32'h801F0010);
    reg_read("R1 readback w1", 3'd1, 32'h01008100);

    // R8: idle cycle gives no response
    @(negedge clk);
    check("R8 idle", {31'd0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      access($sformatf("vec%0d R2/R3/R4/R5/R8", i), VECS[i][27], VECS[i][26:2],
             VECS[i][1], VECS[i][0]);
    end

    // R6: write in the cycle lock is first sampled still lands
    @(negedge clk);
    lock_req = 1'b1; cfg_we = 1'b1; cfg_idx = 3'd3; cfg_wdata = 32'h83050305;
    @(negedge clk);
    lock_req = 1'b0; cfg_we = 1'b0;
    reg_read("R6 same-cycle write", 3'd3, 32'h83050305);
    access("R6 new window active", 1'b1, 25'h0305000, 1'b1, 1'b0);

    // R6: locked writes ignored
    reg_write(3'd0, 32'h00000000);
    reg_read("R6 locked readback", 3'd0, 32'h801F0010);
    access("R6 locked still denies", 1'b1, 25'h0010000, 1'b1, 1'b0);

    // R7: sticky lock, then reset clears all
    repeat (3) @(negedge clk);
    check("R7 lock sticky", {31'd0, lock_q}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R7 lock cleared", {31'd0, lock_q}, 32'd0);
    reg_read("R7 range cleared", 3'd0, 32'd0);
    access("R7 grant after reset", 1'b1, 25'h0010000, 1'b0, 1'b0);
    reg_write(3'd0, 32'h00000000);
    reg_write(3'd0, 32'h801F0010);
    reg_read("R7 writable after reset", 3'd0, 32'h801F0010);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule